// File: doc/BRIEF.md
# Pending-Write Hazard Scoreboard

This block tracks, for one register file, which architectural registers still have a write in flight. Each register owns one pending bit. Instruction issue raises the bit of its destination register. A register-file write port lowers the bit when it actually commits the register. A function unit that finishes without producing its result also lowers it. The block answers two questions about the instruction being presented. Does any source operand it wants to read still wait for a producer (read-after-write)? Is its destination already owed a write by an older instruction (write-after-write)?

The issue request only enters the vector after one pipeline register. An instruction that reads and writes the same register therefore never blocks on itself. All set requests from the issuing units are OR-merged into one vector, and so are all clear requests from write ports and completing units, so no requester overrides another. Register numbers arrive either as binary indices or as one-hot vectors, chosen by a parameter. The hazard outputs are combinational from the registered vector and the current requests. The issue logic can therefore hold the decoded operation steady and retry every cycle until the hazard drops.

Top module: `wr_pending_board`

## Requirements
- R1: After reset every pending bit is 0, so no query reports a hazard.
- R2: When an issue fires with its write flag high, the destination bit is still 0 in the issue cycle and in the cycle after it, and reads 1 from the second cycle after the issue edge on. An issue with its write flag low sets nothing.
- R3: A write port clears the bit of its register only in a cycle where both its grant and its write enable are 1. Either signal high alone leaves the vector unchanged.
- R4: A unit captures its write flag and destination at issue and drops the flag once its busy input is 0. Done with the data-valid input 0 while the captured flag is 1 clears the captured destination. Done with data-valid 1, or after the flag was dropped, clears nothing.
- R5: Set requests from all units and clear requests from all write ports are OR-merged. Two ports clearing different registers in one cycle clear both. Two units issuing different registers in one cycle set both.
- R6: When a set and a clear hit the same bit in the same cycle, the bit ends at 1.
- R7: For each source operand, rd_chk_en is rd_active AND its read flag AND NOT (rd_unit_busy AND no pending hit). rd_hazard is rd_chk_en AND the source register's pending bit.
- R8: waw_hit is wq_valid AND the pending bit of wq_dst. issue_allow is wq_valid AND NOT waw_hit.
- R9: With IDX_FORM binary, index k selects bit k (mask 1 shifted left by k). With IDX_FORM one-hot, the index port is the register mask itself, bit k meaning register k.
- R10: All hazard outputs respond in the same cycle as their query inputs, with no register between request and answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_fire | input | NUM_UNITS (2) | Issue strobe, one per unit |
| iss_wr_en | input | NUM_UNITS (2) | Issued instruction writes a register |
| iss_dst | input | NUM_UNITS*IW (10) | Destination index per unit |
| unit_busy | input | NUM_UNITS (2) | Unit holds an instruction |
| unit_done | input | NUM_UNITS (2) | Unit completion pulse |
| unit_data_ok | input | NUM_UNITS (2) | Unit's result is valid and will be written |
| wp_grant | input | NUM_WPORTS (2) | Write port granted |
| wp_we | input | NUM_WPORTS (2) | Write port write enable |
| wp_dst | input | NUM_WPORTS*IW (10) | Register index per write port |
| rd_active | input | 1 | Querying instruction is active |
| rd_unit_busy | input | 1 | Target unit of the querying instruction is busy |
| rd_flag | input | NUM_SRC (3) | Per-operand read flag |
| rd_src | input | NUM_SRC*IW (15) | Per-operand source index |
| rd_hazard | output | NUM_SRC (3) | Per-operand read-after-write hazard |
| rd_chk_en | output | NUM_SRC (3) | Per-operand hazard check enable |
| wq_valid | input | 1 | Destination query is valid |
| wq_dst | input | IW (5) | Destination index to check |
| waw_hit | output | 1 | Destination has a write outstanding |
| issue_allow | output | 1 | Issue may proceed |

## Verification
Each result has its own due cycle. Query answers are due in the same cycle as their inputs. A clear is due one clock edge after the write or completion that causes it. A destination bit is due two edges after the issue edge. The bench drives inputs just after the falling edge and reads the outputs a fraction of a nanosecond later, still in the low phase. It compares them with a pending-vector model that it advances by those delays. At each stage it sweeps every register through the destination query and, for the read checks, through a source operand.

// File: rtl/scb_pkg.sv
`timescale 1ns/1ps
package scb_pkg;
    typedef enum logic {
        IDX_BINARY = 1'b0,
        IDX_ONEHOT = 1'b1
    } idx_form_e;

    function automatic int idx_width(input int regs, input idx_form_e form);
        if (form == IDX_ONEHOT) return regs;
        return (regs > 1) ? $clog2(regs) : 1;
    endfunction
endpackage

// File: rtl/scb_idx_decode.sv
`timescale 1ns/1ps
module scb_idx_decode
    import scb_pkg::*;
#(
    parameter int        NUM_REGS = 32,
    parameter idx_form_e IDX_FORM = IDX_BINARY,
    localparam int       IW       = idx_width(NUM_REGS, IDX_FORM)
) (
    input  logic [IW-1:0]       idx_i,
    output logic [NUM_REGS-1:0] mask_o
);
    localparam logic [NUM_REGS-1:0] LSB_ONE = 1;

    generate
        if (IDX_FORM == IDX_ONEHOT) begin : g_onehot
            // R9: one-hot form carries the mask directly
            assign mask_o = idx_i;
        end else begin : g_binary
            // R9: binary form, bit k for index k
            assign mask_o = LSB_ONE << idx_i;
        end
    endgenerate
endmodule

// File: rtl/scb_unit_track.sv
`timescale 1ns/1ps
module scb_unit_track #(
    parameter int NUM_REGS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fire_i,
    input  logic                wr_en_i,
    input  logic [NUM_REGS-1:0] dst_mask_i,
    input  logic                busy_i,
    input  logic                done_i,
    input  logic                data_ok_i,
    output logic [NUM_REGS-1:0] done_clr_o
);
    typedef struct packed {
        logic                wr;
        logic [NUM_REGS-1:0] dst;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (fire_i) begin
            trk_d.wr  = wr_en_i;
            trk_d.dst = dst_mask_i;
        end else if (!busy_i) begin
            trk_d.wr = 1'b0;
        end
        done_clr_o = (done_i && trk_q.wr && !data_ok_i) ? trk_q.dst : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    // R4: once idle with no new issue, a later done must clear nothing
    assert_flag_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && !fire_i) |=> (done_clr_o == '0));
endmodule

// File: rtl/scb_hazard_query.sv
`timescale 1ns/1ps
module scb_hazard_query #(
    parameter int NUM_REGS = 32,
    parameter int NUM_SRC  = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_REGS-1:0]               pend_i,
    input  logic                              active_i,
    input  logic                              busy_i,
    input  logic [NUM_SRC-1:0]                flag_i,
    input  logic [NUM_SRC-1:0][NUM_REGS-1:0]  src_mask_i,
    input  logic                              wq_valid_i,
    input  logic [NUM_REGS-1:0]               wq_mask_i,
    output logic [NUM_SRC-1:0]                rd_hazard_o,
    output logic [NUM_SRC-1:0]                rd_chk_en_o,
    output logic                              waw_hit_o,
    output logic                              issue_allow_o
);
    logic [NUM_SRC-1:0] src_hit;

    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            src_hit[s]     = |(pend_i & src_mask_i[s]);
            rd_chk_en_o[s] = active_i && flag_i[s] && !(busy_i && !src_hit[s]);
            rd_hazard_o[s] = rd_chk_en_o[s] && src_hit[s];
        end
        waw_hit_o     = wq_valid_i && (|(pend_i & wq_mask_i));
        issue_allow_o = wq_valid_i && !waw_hit_o;
    end

    // R7: a reported read hazard always has its check enabled
    assert_hazard_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_hazard_o & ~rd_chk_en_o) == '0));
    // R8: a write-after-write hit never lets the issue through
    assert_waw_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        waw_hit_o |-> !issue_allow_o);
endmodule

// File: rtl/wr_pending_board.sv
`timescale 1ns/1ps
module wr_pending_board
    import scb_pkg::*;
#(
    parameter int        NUM_REGS   = 32,
    parameter int        NUM_UNITS  = 2,
    parameter int        NUM_WPORTS = 2,
    parameter int        NUM_SRC    = 3,
    parameter idx_form_e IDX_FORM   = IDX_BINARY,
    localparam int       IW         = idx_width(NUM_REGS, IDX_FORM)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_UNITS-1:0]       iss_fire,
    input  logic [NUM_UNITS-1:0]       iss_wr_en,
    input  logic [NUM_UNITS*IW-1:0]    iss_dst,
    input  logic [NUM_UNITS-1:0]       unit_busy,
    input  logic [NUM_UNITS-1:0]       unit_done,
    input  logic [NUM_UNITS-1:0]       unit_data_ok,
    input  logic [NUM_WPORTS-1:0]      wp_grant,
    input  logic [NUM_WPORTS-1:0]      wp_we,
    input  logic [NUM_WPORTS*IW-1:0]   wp_dst,
    input  logic                       rd_active,
    input  logic                       rd_unit_busy,
    input  logic [NUM_SRC-1:0]         rd_flag,
    input  logic [NUM_SRC*IW-1:0]      rd_src,
    output logic [NUM_SRC-1:0]         rd_hazard,
    output logic [NUM_SRC-1:0]         rd_chk_en,
    input  logic                       wq_valid,
    input  logic [IW-1:0]              wq_dst,
    output logic                       waw_hit,
    output logic                       issue_allow
);
    typedef struct packed {
        logic [NUM_REGS-1:0] pend;
        logic [NUM_REGS-1:0] set_pipe;
    } board_t;

    board_t st_d, st_q;

    logic [NUM_UNITS-1:0][NUM_REGS-1:0]  iss_mask;
    logic [NUM_UNITS-1:0][NUM_REGS-1:0]  done_clr;
    logic [NUM_WPORTS-1:0][NUM_REGS-1:0] wp_mask;
    logic [NUM_SRC-1:0][NUM_REGS-1:0]    src_mask;
    logic [NUM_REGS-1:0]                 wq_mask;
    logic [NUM_REGS-1:0]                 set_now;
    logic [NUM_REGS-1:0]                 clr_mask;

    genvar g;
    generate
        for (g = 0; g < NUM_UNITS; g++) begin : g_unit
            scb_idx_decode #(.NUM_REGS(NUM_REGS), .IDX_FORM(IDX_FORM)) u_dec (
                .idx_i  (iss_dst[g*IW +: IW]),
                .mask_o (iss_mask[g])
            );
            scb_unit_track #(.NUM_REGS(NUM_REGS)) u_trk (
                .clk        (clk),
                .rst_n      (rst_n),
                .fire_i     (iss_fire[g]),
                .wr_en_i    (iss_wr_en[g]),
                .dst_mask_i (iss_mask[g]),
                .busy_i     (unit_busy[g]),
                .done_i     (unit_done[g]),
                .data_ok_i  (unit_data_ok[g]),
                .done_clr_o (done_clr[g])
            );
        end
        for (g = 0; g < NUM_WPORTS; g++) begin : g_wport
            scb_idx_decode #(.NUM_REGS(NUM_REGS), .IDX_FORM(IDX_FORM)) u_dec (
                .idx_i  (wp_dst[g*IW +: IW]),
                .mask_o (wp_mask[g])
            );
        end
        for (g = 0; g < NUM_SRC; g++) begin : g_src
            scb_idx_decode #(.NUM_REGS(NUM_REGS), .IDX_FORM(IDX_FORM)) u_dec (
                .idx_i  (rd_src[g*IW +: IW]),
                .mask_o (src_mask[g])
            );
        end
    endgenerate

    scb_idx_decode #(.NUM_REGS(NUM_REGS), .IDX_FORM(IDX_FORM)) u_wq_dec (
        .idx_i  (wq_dst),
        .mask_o (wq_mask)
    );

    // merge every requester into one set and one clear vector
    always_comb begin
        set_now  = '0;
        clr_mask = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (iss_fire[u] && iss_wr_en[u]) set_now = set_now | iss_mask[u];
            clr_mask = clr_mask | done_clr[u];
        end
        for (int p = 0; p < NUM_WPORTS; p++) begin
            if (wp_grant[p] && wp_we[p]) clr_mask = clr_mask | wp_mask[p];
        end
        st_d.set_pipe = set_now;
        st_d.pend     = (st_q.pend & ~clr_mask) | st_q.set_pipe;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    scb_hazard_query #(.NUM_REGS(NUM_REGS), .NUM_SRC(NUM_SRC)) u_query (
        .clk           (clk),
        .rst_n         (rst_n),
        .pend_i        (st_q.pend),
        .active_i      (rd_active),
        .busy_i        (rd_unit_busy),
        .flag_i        (rd_flag),
        .src_mask_i    (src_mask),
        .wq_valid_i    (wq_valid),
        .wq_mask_i     (wq_mask),
        .rd_hazard_o   (rd_hazard),
        .rd_chk_en_o   (rd_chk_en),
        .waw_hit_o     (waw_hit),
        .issue_allow_o (issue_allow)
    );

    // R2: a pending bit only rises when the delayed issue asked for it
    assert_rise_needs_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.pend & ~$past(st_q.pend) & ~$past(st_q.set_pipe)) == '0));
    // R3: a committed clear without a competing set leaves the bit low
    assert_write_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_mask & ~st_q.set_pipe)) |=> ((st_q.pend & $past(clr_mask & ~st_q.set_pipe)) == '0));
    // R6: a delayed set always lands, even against a clear
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.set_pipe) |=> ((st_q.pend & $past(st_q.set_pipe)) == $past(st_q.set_pipe)));
endmodule

// File: tb/wr_pending_board_test.sv
`timescale 1ns/1ps
module wr_pending_board_test;
    import scb_pkg::*;

    localparam int NR = 32;
    localparam int IW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [1:0]      iss_fire, iss_wr_en, unit_busy, unit_done, unit_data_ok;
    logic [2*IW-1:0] iss_dst;
    logic [1:0]      wp_grant, wp_we;
    logic [2*IW-1:0] wp_dst;
    logic            rd_active, rd_unit_busy;
    logic [2:0]      rd_flag;
    logic [3*IW-1:0] rd_src;
    logic [2:0]      rd_hazard, rd_chk_en;
    logic            wq_valid, waw_hit, issue_allow;
    logic [IW-1:0]   wq_dst;

    wr_pending_board uut (
        .clk(clk), .rst_n(rst_n),
        .iss_fire(iss_fire), .iss_wr_en(iss_wr_en), .iss_dst(iss_dst),
        .unit_busy(unit_busy), .unit_done(unit_done), .unit_data_ok(unit_data_ok),
        .wp_grant(wp_grant), .wp_we(wp_we), .wp_dst(wp_dst),
        .rd_active(rd_active), .rd_unit_busy(rd_unit_busy), .rd_flag(rd_flag),
        .rd_src(rd_src), .rd_hazard(rd_hazard), .rd_chk_en(rd_chk_en),
        .wq_valid(wq_valid), .wq_dst(wq_dst), .waw_hit(waw_hit), .issue_allow(issue_allow)
    );

    // one-hot form, small configuration
    logic       oh_fire, oh_wr, oh_busy, oh_done, oh_ok, oh_grant, oh_we;
    logic       oh_active, oh_rbusy, oh_flag, oh_haz, oh_chk, oh_wqv, oh_hit, oh_allow;
    logic [7:0] oh_dst, oh_wdst, oh_src, oh_wq;

    wr_pending_board #(.NUM_REGS(8), .NUM_UNITS(1), .NUM_WPORTS(1), .NUM_SRC(1),
                       .IDX_FORM(IDX_ONEHOT)) uut_oh (
        .clk(clk), .rst_n(rst_n),
        .iss_fire(oh_fire), .iss_wr_en(oh_wr), .iss_dst(oh_dst),
        .unit_busy(oh_busy), .unit_done(oh_done), .unit_data_ok(oh_ok),
        .wp_grant(oh_grant), .wp_we(oh_we), .wp_dst(oh_wdst),
        .rd_active(oh_active), .rd_unit_busy(oh_rbusy), .rd_flag(oh_flag),
        .rd_src(oh_src), .rd_hazard(oh_haz), .rd_chk_en(oh_chk),
        .wq_valid(oh_wqv), .wq_dst(oh_wq), .waw_hit(oh_hit), .issue_allow(oh_allow)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic [NR-1:0] exp_pend = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs;
        iss_fire = '0; iss_wr_en = '0; iss_dst = '0;
        unit_done = '0; unit_data_ok = '0;
        wp_grant = '0; wp_we = '0; wp_dst = '0;
        rd_active = 1'b0; rd_unit_busy = 1'b0; rd_flag = '0; rd_src = '0;
        wq_valid = 1'b0; wq_dst = '0;
    endtask

    // sweep every register through the destination query (R8, R10)
    task automatic sweep_waw(input string req);
        for (int r = 0; r < NR; r++) begin
            wq_valid = 1'b1;
            wq_dst   = IW'(r);
            #0.05;
            chk(req, {31'd0, waw_hit}, {31'd0, exp_pend[r]});
            chk(req, {31'd0, issue_allow}, {31'd0, !exp_pend[r]});
        end
        wq_valid = 1'b0;
    endtask

    task automatic issue(input int u, input int r, input logic wr);
        iss_fire[u]  = 1'b1;
        iss_wr_en[u] = wr;
        iss_dst[u*IW +: IW] = IW'(r);
    endtask

    task automatic wport(input int p, input int r, input logic g, input logic w);
        wp_grant[p] = g;
        wp_we[p]    = w;
        wp_dst[p*IW +: IW] = IW'(r);
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        unit_busy = '0;
        oh_fire = 0; oh_wr = 0; oh_busy = 0; oh_done = 0; oh_ok = 0; oh_grant = 0; oh_we = 0;
        oh_active = 0; oh_rbusy = 0; oh_flag = 0; oh_wqv = 0;
        oh_dst = '0; oh_wdst = '0; oh_src = '0; oh_wq = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: all clear after reset
        sweep_waw("R1");

        // R2: self-dependency, bit not visible until two edges after issue
        issue(0, 5, 1'b1);
        rd_active = 1'b1; rd_flag = 3'b001; rd_src[0 +: IW] = 5'd5;
        #0.05 chk("R2 issue cycle", {29'd0, rd_hazard}, 32'd0);
        tick();
        idle_inputs();
        rd_active = 1'b1; rd_flag = 3'b001; rd_src[0 +: IW] = 5'd5;
        #0.05 chk("R2 next cycle", {29'd0, rd_hazard}, 32'd0);
        tick();
        #0.05 chk("R2 second cycle", {29'd0, rd_hazard}, 32'd1);
        idle_inputs();
        exp_pend[5] = 1'b1;
        sweep_waw("R2");
        issue(1, 6, 1'b0);
        tick(); idle_inputs(); tick();
        sweep_waw("R2 no write flag");

        // R3: clear needs both grant and write enable
        wport(0, 5, 1'b1, 1'b0); tick(); idle_inputs();
        sweep_waw("R3 grant only");
        wport(0, 5, 1'b0, 1'b1); tick(); idle_inputs();
        sweep_waw("R3 we only");
        wport(0, 5, 1'b1, 1'b1); tick(); idle_inputs();
        exp_pend[5] = 1'b0;
        sweep_waw("R3");

        // R5: merged sets from two units, merged clears from two ports
        issue(0, 7, 1'b1); issue(1, 9, 1'b1);
        tick(); idle_inputs(); tick();
        exp_pend[7] = 1'b1; exp_pend[9] = 1'b1;
        sweep_waw("R5 sets");
        wport(0, 7, 1'b1, 1'b1); wport(1, 9, 1'b1, 1'b1);
        tick(); idle_inputs();
        exp_pend[7] = 1'b0; exp_pend[9] = 1'b0;
        sweep_waw("R5 clears");

        // R6: set beats clear on the same bit
        issue(0, 3, 1'b1); tick(); idle_inputs(); tick();
        exp_pend[3] = 1'b1;
        issue(1, 3, 1'b1); tick(); idle_inputs();
        wport(1, 3, 1'b1, 1'b1); tick(); idle_inputs();
        sweep_waw("R6");
        wport(0, 3, 1'b1, 1'b1); tick(); idle_inputs();
        exp_pend[3] = 1'b0;
        sweep_waw("R6 later clear");

        // R4: completion without data clears; with data or after idle does not
        unit_busy[0] = 1'b1;
        issue(0, 12, 1'b1); tick(); idle_inputs(); tick();
        exp_pend[12] = 1'b1;
        sweep_waw("R4 set");
        unit_done[0] = 1'b1; unit_data_ok[0] = 1'b0; tick(); idle_inputs();
        exp_pend[12] = 1'b0;
        sweep_waw("R4 done no data");
        issue(0, 13, 1'b1); tick(); idle_inputs(); tick();
        exp_pend[13] = 1'b1;
        unit_done[0] = 1'b1; unit_data_ok[0] = 1'b1; tick(); idle_inputs();
        sweep_waw("R4 done with data");
        unit_busy[0] = 1'b0; tick();
        unit_done[0] = 1'b1; unit_data_ok[0] = 1'b0; tick(); idle_inputs();
        sweep_waw("R4 flag dropped");
        wport(0, 13, 1'b1, 1'b1); tick(); idle_inputs();
        exp_pend[13] = 1'b0;

        // R7: read hazard and its enable
        issue(1, 20, 1'b1); tick(); idle_inputs(); tick();
        exp_pend[20] = 1'b1;
        rd_active = 1'b1; rd_flag = 3'b011;
        rd_src = {5'd20, 5'd21, 5'd20};
        #0.05;
        chk("R7 hazard idle unit", {29'd0, rd_hazard}, 32'b001);
        chk("R7 enable idle unit", {29'd0, rd_chk_en}, 32'b011);
        rd_unit_busy = 1'b1;
        #0.05;
        chk("R7 hazard busy unit", {29'd0, rd_hazard}, 32'b001);
        chk("R7 enable busy unit", {29'd0, rd_chk_en}, 32'b001);
        rd_active = 1'b0;
        #0.05;
        chk("R7 inactive", {26'd0, rd_chk_en, rd_hazard}, 32'd0);
        rd_active = 1'b1; rd_unit_busy = 1'b0; rd_flag = 3'b001;
        for (int r = 0; r < NR; r++) begin
            rd_src[0 +: IW] = IW'(r);
            #0.05 chk("R7 sweep", {31'd0, rd_hazard[0]}, {31'd0, exp_pend[r]});
        end
        idle_inputs();

        // R8: invalid query never allows or hits
        wq_valid = 1'b0; wq_dst = 5'd20;
        #0.05 chk("R8 invalid", {30'd0, waw_hit, issue_allow}, 32'd0);
        wport(0, 20, 1'b1, 1'b1); tick(); idle_inputs();
        exp_pend[20] = 1'b0;
        sweep_waw("R8");

        // R9: one-hot index form
        oh_wqv = 1'b1; oh_wq = 8'b0001_0000;
        #0.05 chk("R9 one-hot reset", {31'd0, oh_hit}, 32'd0);
        oh_fire = 1'b1; oh_wr = 1'b1; oh_dst = 8'b0001_0000;
        tick(); oh_fire = 1'b0; tick();
        #0.05 chk("R9 one-hot set", {30'd0, oh_hit, oh_allow}, 32'b10);
        oh_wq = 8'b0000_1000;
        #0.05 chk("R9 one-hot other", {30'd0, oh_hit, oh_allow}, 32'b01);
        oh_grant = 1'b1; oh_we = 1'b1; oh_wdst = 8'b0001_0000;
        tick(); oh_grant = 1'b0; oh_we = 1'b0;
        oh_wq = 8'b0001_0000;
        #0.05 chk("R9 one-hot clear", {31'd0, oh_hit}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule